// File: doc/BRIEF.md
# Prioritised Multi-Channel Copy Engine

This block moves data for several independent channels over one shared memory port. Each channel is set up with a 32-bit control word and a starting source and destination pointer. The control word sets how far each pointer moves after a transfer, the data size, how many transfers to make, and how often the channel must give the port back. The host raises a per-channel request line. While that line is high and the channel has work left, the engine copies one item at a time: a read from the source pointer, then a write of the same data to the destination pointer.

Only one channel owns the port at any moment. When the port is free, the lowest-numbered channel that is both requesting and armed wins it. The winner keeps the port for a burst of 2^P transfers, where P is the channel's pause exponent. After the burst the port goes back to arbitration, so a higher-priority channel that asked in the meantime takes over. The paused channel keeps its pointers and its remaining count, and it resumes where it stopped when it next wins.

When a channel finishes its last transfer, the block pulses that channel's done line and the channel returns to idle. A control word with an illegal combination of codes is refused at load time. The refused channel raises its error line and makes no transfer.

Top module: `dma_xfer_seq`

## Requirements
- R1: Control word layout: bits 31:30 destination step code, 29:28 destination size code, 27:26 source step code, 25:24 source size code, 17:14 pause exponent P, 13:4 transfer count minus one, 2:0 mode. Bits 23:18 and bit 3 are ignored.
- R2: Step code 0 advances a pointer by 1 byte, code 1 by 2, code 2 by 4, and code 3 leaves it unchanged. This applies to both pointers independently.
- R3: Size code 0 means byte, 1 means halfword and 2 means word, and it is driven on rd_size and wr_size. A load is refused if the size codes differ, if the size code is 3, or if a step code other than 3 is smaller than the size code. A refused load sets err for that channel, which stays set until the next load, and the channel makes no transfer.
- R4: A valid load makes exactly count-minus-one + 1 transfers, from 1 to 1024.
- R5: Each transfer is one read handshake (rd_valid and rd_ready high at a clock edge) followed by one write handshake (wr_valid and wr_ready high). The write carries the data returned by the read. The address stays stable while the port is stalled.
- R6: When the port is free, the lowest-indexed channel that is armed and requesting is granted. xfer_ch shows the owner.
- R7: For P below 10, a channel gives up the port after 2^P consecutive transfers. The port is then re-arbitrated, and a higher-priority requester preempts the channel.
- R8: For P of 10 or more, a channel is never paused and runs to completion while it keeps requesting.
- R9: A preempted channel resumes with its pointers and remaining count as they were when it stopped.
- R10: done for a channel pulses high for exactly one cycle, in the cycle after its last write handshake. The channel then goes idle and a held request causes no further transfer.
- R11: After reset, busy, rd_valid, wr_valid, done and err are all low.
- R12: A load with mode 0 leaves the channel idle, makes no transfer and does not raise err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for one channel |
| cfg_ch | input | CHW | Channel index being loaded |
| cfg_word | input | 32 | Control word |
| cfg_src | input | AW | Initial source pointer |
| cfg_dst | input | AW | Initial destination pointer |
| req | input | NCH | Per-channel request lines |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read size code |
| rd_data | input | DW | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | DW | Write data |
| xfer_ch | output | CHW | Channel owning the port |
| busy | output | 1 | Port owned by a channel |
| done | output | NCH | Per-channel completion pulse |
| err | output | NCH | Per-channel refused-load flag |

## Verification
The assertions assume that a channel is never reloaded while it owns the port, and that the memory side holds rd_data valid in the cycle where it raises rd_ready. The stimulus loads each channel only while the port is idle or owned by another channel. It returns read data as a fixed arithmetic function of the read address. It drives the ready lines from a pseudo-random pattern, so stalls occur in both the read phase and the write phase. Every step and size code combination is swept on one channel. The priority cases raise a higher-priority request only after the lower one has taken the port.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

   localparam int CTRL_W       = 32;
   localparam int NM1_W        = 10;
   localparam int CNT_W        = NM1_W + 1;
   localparam int RPOW_W       = 4;
   localparam int RPOW_NOPAUSE = 10;
   localparam int MODE_W       = 3;

   // field order is behaviour: the host composes words in this layout
   typedef struct packed {
      logic [1:0]        dst_step;
      logic [1:0]        dst_sz;
      logic [1:0]        src_step;
      logic [1:0]        src_sz;
      logic [5:0]        spare_hi;
      logic [RPOW_W-1:0] pause_exp;
      logic [NM1_W-1:0]  count_m1;
      logic              spare_lo;
      logic [MODE_W-1:0] mode;
   } ctrl_word_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } eng_state_e;

   function automatic logic [2:0] step_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic step_fits(input logic [1:0] code, input logic [1:0] sz);
      return (code == 2'd3) || (code >= sz);
   endfunction

   function automatic logic ctrl_legal(input ctrl_word_t w);
      return (w.src_sz == w.dst_sz) && (w.src_sz != 2'd3)
             && step_fits(w.src_step, w.src_sz)
             && step_fits(w.dst_step, w.dst_sz);
   endfunction

endpackage

// File: rtl/dseq_prio_arb.sv
module dseq_prio_arb #(
   parameter int NCH = 4,
   parameter int CHW = 2
) (
   input  logic [NCH-1:0] elig,
   output logic           any,
   output logic [CHW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (elig[i]) idx = CHW'(i);
      end
   end

   assign any = |elig;

endmodule

// File: rtl/dseq_channel.sv
module dseq_channel
   import dseq_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CTRL_W-1:0] load_word,
   input  logic [AW-1:0]     load_src,
   input  logic [AW-1:0]     load_dst,
   input  logic              step,
   output logic              active,
   output logic              err,
   output logic              done,
   output logic              last,
   output logic [AW-1:0]     src,
   output logic [AW-1:0]     dst,
   output logic [1:0]        size,
   output logic [RPOW_W-1:0] rpow
);

   ctrl_word_t        lw;
   logic [MODE_W-1:0] mode_q;
   logic [1:0]        sstep_q, dstep_q, size_q;
   logic [RPOW_W-1:0] rpow_q;
   logic [CNT_W-1:0]  rem_q;
   logic [AW-1:0]     src_q, dst_q;
   logic              err_q, done_q;
   logic              unused_spare;

   assign lw           = ctrl_word_t'(load_word);
   assign unused_spare = ^{lw.spare_hi, lw.spare_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         sstep_q <= '0;
         dstep_q <= '0;
         size_q  <= '0;
         rpow_q  <= '0;
         rem_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else if (load) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         sstep_q <= lw.src_step;
         dstep_q <= lw.dst_step;
         size_q  <= lw.src_sz;
         rpow_q  <= lw.pause_exp;
         rem_q   <= CNT_W'({1'b0, lw.count_m1}) + CNT_W'(1);
         src_q   <= load_src;
         dst_q   <= load_dst;
         if (lw.mode == '0) begin
            mode_q <= '0;
         end else if (!ctrl_legal(lw)) begin
            mode_q <= '0;
            err_q  <= 1'b1;
         end else begin
            mode_q <= lw.mode;
         end
      end else begin
         done_q <= 1'b0;
         if (step && (mode_q != '0)) begin
            src_q <= src_q + AW'(step_bytes(sstep_q));
            dst_q <= dst_q + AW'(step_bytes(dstep_q));
            rem_q <= rem_q - CNT_W'(1);
            if (rem_q == CNT_W'(1)) begin
               mode_q <= '0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign active = (mode_q != '0);
   assign err    = err_q;
   assign done   = done_q;
   assign last   = (rem_q == CNT_W'(1));
   assign src    = src_q;
   assign dst    = dst_q;
   assign size   = size_q;
   assign rpow   = rpow_q;

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !active);
   a_r4_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (rem_q != '0));
   a_r9_state_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> ($stable(src_q) && $stable(dst_q) && $stable(rem_q)));

endmodule

// File: rtl/dseq_engine.sv
module dseq_engine
   import dseq_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CHW = 2,
   parameter int AW  = 32,
   parameter int DW  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    elig,
   input  logic              grant_any,
   input  logic [CHW-1:0]    grant_idx,
   input  logic [AW-1:0]     sel_src,
   input  logic [AW-1:0]     sel_dst,
   input  logic [1:0]        sel_size,
   input  logic [RPOW_W-1:0] sel_rpow,
   input  logic              sel_last,
   output logic [CHW-1:0]    cur_ch,
   output logic              step,
   output logic              busy,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [AW-1:0]     rd_addr,
   output logic [1:0]        rd_size,
   input  logic [DW-1:0]     rd_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [AW-1:0]     wr_addr,
   output logic [1:0]        wr_size,
   output logic [DW-1:0]     wr_data
);

   localparam int BURST_W = CNT_W;

   eng_state_e           state_q;
   logic [CHW-1:0]       cur_q;
   logic [BURST_W-1:0]   burst_q, burst_nx, burst_cap;
   logic [DW-1:0]        data_q;
   logic                 pausable, cap_hit, keep_going;

   assign pausable   = (sel_rpow < RPOW_W'(RPOW_NOPAUSE));
   assign burst_cap  = BURST_W'(1) << sel_rpow;
   assign burst_nx   = burst_q + BURST_W'(1);
   assign cap_hit    = pausable && (burst_nx == burst_cap);
   assign keep_going = !sel_last && !cap_hit && elig[cur_q];
   assign step       = (state_q == ST_WRITE) && wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         burst_q <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (grant_any) begin
                  cur_q   <= grant_idx;
                  burst_q <= '0;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (rd_ready) begin
                  data_q  <= rd_data;
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_ready) begin
                  burst_q <= burst_nx;
                  state_q <= keep_going ? ST_READ : ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cur_ch   = cur_q;
   assign busy     = (state_q != ST_IDLE);
   assign rd_valid = (state_q == ST_READ);
   assign rd_addr  = sel_src;
   assign rd_size  = sel_size;
   assign wr_valid = (state_q == ST_WRITE);
   assign wr_addr  = sel_dst;
   assign wr_size  = sel_size;
   assign wr_data  = data_q;

   a_r5_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
   a_r5_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> (wr_valid && $stable(cur_ch) && (wr_data == $past(rd_data))));
   a_r5_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
   a_r6_grant_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && grant_any) |=> (rd_valid && elig[cur_ch]));
   a_r7_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pausable) |-> (burst_q < burst_cap));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dseq_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 32,
   parameter int DW  = 32,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CHW-1:0]    cfg_ch,
   input  logic [CTRL_W-1:0] cfg_word,
   input  logic [AW-1:0]     cfg_src,
   input  logic [AW-1:0]     cfg_dst,
   input  logic [NCH-1:0]    req,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [AW-1:0]     rd_addr,
   output logic [1:0]        rd_size,
   input  logic [DW-1:0]     rd_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [AW-1:0]     wr_addr,
   output logic [1:0]        wr_size,
   output logic [DW-1:0]     wr_data,
   output logic [CHW-1:0]    xfer_ch,
   output logic              busy,
   output logic [NCH-1:0]    done,
   output logic [NCH-1:0]    err
);

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("dma_xfer_seq: NCH must be within 1..32");
   end
   if (AW < 8) begin : g_bad_aw
      $error("dma_xfer_seq: AW must be at least 8");
   end
   if (DW < 32) begin : g_bad_dw
      $error("dma_xfer_seq: DW must hold a word");
   end

   logic [NCH-1:0]    ch_active, ch_last, elig;
   logic [AW-1:0]     ch_src  [NCH];
   logic [AW-1:0]     ch_dst  [NCH];
   logic [1:0]        ch_size [NCH];
   logic [RPOW_W-1:0] ch_rpow [NCH];
   logic              grant_any, eng_step;
   logic [CHW-1:0]    grant_idx, cur_ch;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dseq_channel #(.AW(AW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (cfg_we && (cfg_ch == CHW'(g))),
         .load_word(cfg_word),
         .load_src (cfg_src),
         .load_dst (cfg_dst),
         .step     (eng_step && (cur_ch == CHW'(g))),
         .active   (ch_active[g]),
         .err      (err[g]),
         .done     (done[g]),
         .last     (ch_last[g]),
         .src      (ch_src[g]),
         .dst      (ch_dst[g]),
         .size     (ch_size[g]),
         .rpow     (ch_rpow[g])
      );
   end

   assign elig = ch_active & req;

   dseq_prio_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
      .elig(elig),
      .any (grant_any),
      .idx (grant_idx)
   );

   dseq_engine #(.NCH(NCH), .CHW(CHW), .AW(AW), .DW(DW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (elig),
      .grant_any(grant_any),
      .grant_idx(grant_idx),
      .sel_src  (ch_src[cur_ch]),
      .sel_dst  (ch_dst[cur_ch]),
      .sel_size (ch_size[cur_ch]),
      .sel_rpow (ch_rpow[cur_ch]),
      .sel_last (ch_last[cur_ch]),
      .cur_ch   (cur_ch),
      .step     (eng_step),
      .busy     (busy),
      .rd_valid (rd_valid),
      .rd_ready (rd_ready),
      .rd_addr  (rd_addr),
      .rd_size  (rd_size),
      .rd_data  (rd_data),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .wr_addr  (wr_addr),
      .wr_size  (wr_size),
      .wr_data  (wr_data)
   );

   assign xfer_ch = cur_ch;

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |-> ((done & ch_active) == '0));
   a_r6_owner_active: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ch_active[cur_ch]);

endmodule

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
   localparam int NCH  = 4;
   localparam int AW   = 32;
   localparam int DW   = 32;
   localparam int CHW  = 2;
   localparam int LOGN = 4096;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [CHW-1:0] cfg_ch = '0;
   logic [31:0]    cfg_word = '0;
   logic [AW-1:0]  cfg_src = '0, cfg_dst = '0;
   logic [NCH-1:0] req = '0;
   logic           rd_valid, wr_valid, busy;
   logic           rd_ready = 1'b1, wr_ready = 1'b1;
   logic [AW-1:0]  rd_addr, wr_addr;
   logic [1:0]     rd_size, wr_size;
   logic [DW-1:0]  rd_data, wr_data;
   logic [CHW-1:0] xfer_ch;
   logic [NCH-1:0] done, err;

   always #4 clk = ~clk;

   dma_xfer_seq #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_word(cfg_word),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .req(req),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
      .xfer_ch(xfer_ch), .busy(busy), .done(done), .err(err)
   );

   function automatic logic [31:0] mem_f(input logic [31:0] a);
      return {~a[15:0], a[15:0]} ^ 32'h5A00_00C3;
   endfunction

   assign rd_data = mem_f(rd_addr);

   function automatic int step_of(input int code);
      return (code == 3) ? 0 : (1 << code);
   endfunction

   function automatic logic [31:0] mk_word(input int di, input int dsz, input int si, input int ssz,
                                            input int rp, input int nm1, input int mode);
      return {di[1:0], dsz[1:0], si[1:0], ssz[1:0], 6'b101010, rp[3:0], nm1[9:0], 1'b1, mode[2:0]};
   endfunction

   int n_chk = 0, n_bad = 0;
   int cyc = 0, nw = 0, dbl_done = 0;
   int w_ch [LOGN];
   logic [31:0] w_addr [LOGN];
   logic [31:0] w_data [LOGN];
   logic [1:0]  w_size [LOGN];
   int done_cnt [NCH];
   int done_cyc [NCH];
   int last_wr_cyc [NCH];
   logic [NCH-1:0] prev_done = '0;
   logic stall_on = 1'b0;
   logic [7:0] lfsr = 8'h9D;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(negedge clk) begin
      cyc++;
      if (wr_valid && wr_ready && nw < LOGN) begin
         w_ch[nw]   = int'(xfer_ch);
         w_addr[nw] = wr_addr;
         w_data[nw] = wr_data;
         w_size[nw] = wr_size;
         last_wr_cyc[int'(xfer_ch)] = cyc;
         nw++;
      end
      for (int i = 0; i < NCH; i++) begin
         if (done[i]) begin
            done_cnt[i]++;
            done_cyc[i] = cyc;
            if (prev_done[i]) dbl_done++;
         end
      end
      prev_done = done;
   end

   initial begin
      forever begin
         @(posedge clk);
         #1;
         lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         rd_ready = stall_on ? (lfsr[0] | lfsr[2]) : 1'b1;
         wr_ready = stall_on ? (lfsr[1] | lfsr[4]) : 1'b1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      summary();
      $finish;
   end

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic load(input int ch, input logic [31:0] w, input logic [31:0] s, input logic [31:0] d);
      cfg_ch   = CHW'(ch);
      cfg_word = w;
      cfg_src  = s;
      cfg_dst  = d;
      cfg_we   = 1'b1;
      tick(1);
      cfg_we   = 1'b0;
   endtask

   task automatic clear_logs();
      nw = 0;
      dbl_done = 0;
      for (int i = 0; i < NCH; i++) done_cnt[i] = 0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      int lim = 0;
      while (q < 6 && lim < 8000) begin
         tick(1);
         q = busy ? 0 : q + 1;
         lim++;
      end
   endtask

   task automatic wait_writes(input int n);
      int lim = 0;
      while (nw < n && lim < 2000) begin
         tick(1);
         lim++;
      end
   endtask

   // check a run of writes for one channel against arithmetic pointers
   task automatic chk_run(input string tag, input int first, input int cnt, input int ch,
                          input logic [31:0] s0, input int si, input logic [31:0] d0, input int di,
                          input int base_k, input int sz);
      for (int k = 0; k < cnt; k++) begin
         logic [31:0] ea, es;
         ea = d0 + 32'((base_k + k) * step_of(di));
         es = s0 + 32'((base_k + k) * step_of(si));
         chk({tag, " R6 owner"}, w_ch[first + k], ch);
         chk({tag, " R2 dst addr"}, w_addr[first + k], ea);
         chk({tag, " R5 data"}, w_data[first + k], mem_f(es));
         chk({tag, " R3 size"}, w_size[first + k], sz);
      end
   endtask

   initial begin
      tick(3);
      // R11: reset state
      chk("R11 busy", busy, 0);
      chk("R11 rd_valid", rd_valid, 0);
      chk("R11 wr_valid", wr_valid, 0);
      chk("R11 done", done, 0);
      chk("R11 err", err, 0);
      rst_n = 1'b1;
      tick(2);

      // R1 R2 R3 R4 R5 R10: sweep every size and step code on channel 1, with stalls
      stall_on = 1'b1;
      for (int sz = 0; sz < 4; sz++) begin
         for (int si = 0; si < 4; si++) begin
            for (int di = 0; di < 4; di++) begin
               bit ok;
               ok = (sz != 3) && (si == 3 || si >= sz) && (di == 3 || di >= sz);
               clear_logs();
               load(1, mk_word(di, sz, si, sz, 15, 2, 1), 32'h1000, 32'h8000);
               req[1] = 1'b1;
               wait_quiet();
               if (ok) begin
                  chk("R4 count", nw, 3);
                  if (nw == 3) chk_run("sweep", 0, 3, 1, 32'h1000, si, 32'h8000, di, 0, sz);
                  chk("R3 err clear", err[1], 0);
                  chk("R10 done once", done_cnt[1], 1);
                  chk("R10 done timing", done_cyc[1], last_wr_cyc[1] + 1);
                  chk("R10 pulse width", dbl_done, 0);
               end else begin
                  chk("R3 refused no transfer", nw, 0);
                  chk("R3 refused err", err[1], 1);
                  chk("R3 refused no done", done_cnt[1], 0);
               end
               req[1] = 1'b0;
               tick(1);
            end
         end
      end

      // R3: mismatched sizes refused
      clear_logs();
      load(1, mk_word(1, 1, 1, 0, 15, 2, 1), 32'h1000, 32'h8000);
      req[1] = 1'b1;
      wait_quiet();
      chk("R3 mismatch no transfer", nw, 0);
      chk("R3 mismatch err", err[1], 1);
      req[1] = 1'b0;

      // R12: mode 0 is idle without error
      clear_logs();
      load(1, mk_word(0, 0, 0, 0, 15, 2, 0), 32'h1000, 32'h8000);
      chk("R12 err cleared", err[1], 0);
      req[1] = 1'b1;
      wait_quiet();
      chk("R12 no transfer", nw, 0);
      chk("R12 no done", done_cnt[1], 0);
      req[1] = 1'b0;
      stall_on = 1'b0;
      tick(1);

      // R7 R9: ch3 pauses every 2 transfers, ch1 preempts, ch3 resumes
      clear_logs();
      load(3, mk_word(2, 2, 2, 2, 1, 5, 1), 32'h2000, 32'h3000);
      load(1, mk_word(0, 0, 0, 0, 10, 3, 1), 32'h0400, 32'h0500);
      req[3] = 1'b1;
      wait_writes(1);
      req[1] = 1'b1;
      wait_quiet();
      chk("R7 total", nw, 10);
      if (nw == 10) begin
         chk_run("R7 first burst", 0, 2, 3, 32'h2000, 2, 32'h3000, 2, 0, 2);
         chk_run("R7 preempt", 2, 4, 1, 32'h0400, 0, 32'h0500, 0, 0, 0);
         chk_run("R9 resume", 6, 4, 3, 32'h2000, 2, 32'h3000, 2, 2, 2);
      end
      chk("R10 ch3 done", done_cnt[3], 1);
      chk("R10 ch1 done", done_cnt[1], 1);
      req = '0;
      tick(1);

      // R8: pause exponent 12 on ch2 is never interrupted by ch0
      clear_logs();
      load(2, mk_word(1, 1, 1, 1, 12, 4, 1), 32'h6000, 32'h7000);
      load(0, mk_word(3, 0, 0, 0, 0, 1, 1), 32'h0100, 32'h0200);
      req[2] = 1'b1;
      wait_writes(1);
      req[0] = 1'b1;
      wait_quiet();
      chk("R8 total", nw, 7);
      if (nw == 7) begin
         chk_run("R8 no pause", 0, 5, 2, 32'h6000, 1, 32'h7000, 1, 0, 1);
         chk_run("R8 then ch0", 5, 2, 0, 32'h0100, 0, 32'h0200, 3, 0, 0);
      end
      req = '0;
      tick(1);

      // R6 R7: P=0 on both, ch0 re-wins every arbitration
      clear_logs();
      load(0, mk_word(0, 0, 0, 0, 0, 2, 2), 32'h0A00, 32'h0B00);
      load(1, mk_word(0, 0, 0, 0, 0, 1, 3), 32'h0C00, 32'h0D00);
      req[0] = 1'b1;
      req[1] = 1'b1;
      wait_quiet();
      chk("R6 total", nw, 5);
      if (nw == 5) begin
         chk_run("R6 ch0 first", 0, 3, 0, 32'h0A00, 0, 32'h0B00, 0, 0, 0);
         chk_run("R6 ch1 after", 3, 2, 1, 32'h0C00, 0, 32'h0D00, 0, 0, 0);
      end
      req = '0;
      tick(1);

      // R4: count extremes 1 and 1024
      clear_logs();
      load(2, mk_word(0, 0, 0, 0, 15, 0, 1), 32'h0E00, 32'h0F00);
      req[2] = 1'b1;
      wait_quiet();
      chk("R4 single", nw, 1);
      chk("R10 single done", done_cnt[2], 1);
      req = '0;
      clear_logs();
      load(0, mk_word(0, 0, 0, 0, 15, 1023, 1), 32'h1_0000, 32'h2_0000);
      req[0] = 1'b1;
      wait_quiet();
      chk("R4 full count", nw, 1024);
      if (nw == 1024) begin
         chk("R4 last addr", w_addr[1023], 32'h2_0000 + 32'd1023);
         chk("R4 last data", w_data[1023], mem_f(32'h1_0000 + 32'd1023));
      end
      // R10: held request after completion causes nothing
      tick(20);
      chk("R10 idle after done", nw, 1024);
      chk("R10 full done", done_cnt[0], 1);
      req = '0;
      tick(2);

      summary();
      $finish;
   end

endmodule